// File: doc/BRIEF.md
# SMBus Target with Alert Response

This block is the serial-bus target of a small control chip. It watches SCL and SDA, which it samples with a fast system clock, and pulls SDA low through an open-drain enable. Behind it sits a register space of 32 entries, 8 bits each. The register file attaches through a write strobe and a read strobe. Both share a 5-bit register pointer, and the read data is expected back in the same cycle.

The block handles four transfers. A one-byte write sends a command byte and then a data byte. A one-byte read sends a command byte, then a repeated START and a read address. A bare read, with no command byte, returns register 0, because the pointer returns to zero at every STOP. The last transfer is the alert query: several chips share one active-low interrupt line, and the host uses the query to find which of them raised it. The block answers the query only while its interrupt input is pending. It replies with its own address, loses arbitration cleanly to a chip with a lower address, and pulses an acknowledge output when its reply wins.

Top module: `smb_alert_target`

## Requirements
- R1: A byte is taken only after a START, which is SDA falling while SCL is high. A STOP, which is SDA rising while SCL is high, ends the transfer and leaves the block idle, so clocked bits without a new START are not acknowledged.
- R2: The own 7-bit address is 010 followed by the strap pins A3..A0. Any other address is not acknowledged, and SDA stays released until the next START or STOP.
- R3: The block acknowledges by holding SDA low through the whole high phase of the ninth clock.
- R4: In a write, only bits 4..0 of the command byte become the register pointer, and bits 7..5 are ignored. The data byte is acknowledged and written with a one-cycle write strobe at that pointer.
- R5: A command byte followed by a repeated START and the own address with the read bit set returns the pointed register, most significant bit first.
- R6: Every STOP clears the pointer to 0, so a read that comes directly after a START returns register 0.
- R7: Address 0001100 with the read bit set is acknowledged only while the interrupt input is high. The reply is the own 7-bit address followed by a 1.
- R8: During the alert reply, if SDA reads 0 in a bit where the block sent a 1, the block releases SDA for the rest of the reply and does not signal an alert acknowledge.
- R9: A reply that completes with arbitration won produces exactly one single-cycle pulse on the alert acknowledge output.
- R10: The SDA drive changes only while the filtered SCL is low.
- R11: A START in the middle of a byte abandons that byte and begins a new address phase.
- R12: Pulses on SCL or SDA shorter than GLITCH_CYC system clocks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_addr | input | 4 | Low four address bits |
| irq_pending | input | 1 | Interrupt pending in this chip |
| reg_addr | output | 5 | Register pointer |
| reg_rd_en | output | 1 | Read strobe, one cycle |
| reg_rd_data | input | 8 | Register contents at reg_addr, same cycle |
| reg_wr_en | output | 1 | Write strobe, one cycle |
| reg_wr_data | output | 8 | Data to write |
| alert_ack | output | 1 | One-cycle pulse after a won alert reply |

## Verification
The hardest case to reach from the ports is a lost alert arbitration. A second bus driver has to pull SDA low in the same bit in which this block sends a 1, and the loss only shows in a later bit, where the block sends a 0 and the rival sends a 1. The bench models the wired-AND line and plays a rival whose address differs from the block's address in exactly that pattern. It then checks that the line carries the rival's byte and that no alert acknowledge appears. Short pulses are also hard to place, so the bench puts a two-cycle SCL pulse inside a command byte and a two-cycle SDA dip into an idle bus, then checks that neither one disturbs the byte alignment or the idle state.

// File: rtl/smbt_pkg.sv
// Package: constants and state types shared by the SMBus target blocks.
package smbt_pkg;
    localparam logic [6:0] ALERT_QUERY_ADDR = 7'b0001100;
    localparam logic [2:0] OWN_ADDR_PREFIX  = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_IGNORE
    } xfer_state_t;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_CMD,
        ROLE_DATA
    } byte_role_t;
endpackage

// File: rtl/smbt_line_filter.sv
// Line filter: a two-flop synchronizer followed by a persistence filter.
// The output follows the input only after the synchronized level has held a
// new value for GLITCH_CYC consecutive clocks. Assumes an idle-high line.
module smbt_line_filter #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_f
);
    localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;

    logic          sync1, sync2;
    logic [CW-1:0] cnt;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line_i;
            sync2 <= sync1;
        end
    end

    // Accept a new level only once it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_f <= 1'b1;
            cnt    <= '0;
        end else if (sync2 == line_f) begin
            cnt <= '0;
        end else if (cnt == CW'(GLITCH_CYC - 1)) begin
            line_f <= sync2;
            cnt    <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r12_change_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_f) |-> ($past(sync2) != $past(line_f)));
endmodule

// File: rtl/smbt_xfer_fsm.sv
// Transfer engine: finds START and STOP in the filtered lines, shifts bytes,
// decodes the address, acknowledges, moves the register pointer and returns
// register or alert-reply bytes. Assumes glitch-free SCL/SDA and a register
// file whose read data is valid in the same cycle as reg_addr.
module smbt_xfer_fsm
    import smbt_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [3:0]        strap_addr,
    input  logic              irq_pending,
    input  logic [DW-1:0]     reg_rd_data,
    output logic              sda_oe,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic [DW-1:0]     reg_wr_data,
    output logic              alert_ack
);
    localparam int BCW = $clog2(DW + 1);

    xfer_state_t    state;
    byte_role_t     role;
    logic [BCW-1:0] bitcnt;
    logic [DW-1:0]  shreg, txsh;
    logic           scl_q, sda_q, is_rd, is_ara;
    logic [6:0]     own_addr;
    logic           scl_rise, scl_fall, start_c, stop_c;

    // Bus conditions, found from the previous filtered levels.
    always_comb begin
        own_addr = {OWN_ADDR_PREFIX, strap_addr};
        scl_rise = scl_f & ~scl_q;
        scl_fall = ~scl_f & scl_q;
        start_c  = scl_f & scl_q & sda_q & ~sda_f;
        stop_c   = scl_f & scl_q & ~sda_q & sda_f;
    end

    // Main transfer sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;   role <= ROLE_ADDR;  bitcnt <= '0;
            shreg <= '0;        txsh <= '0;         reg_addr <= '0;
            sda_oe <= 1'b0;     scl_q <= 1'b1;      sda_q <= 1'b1;
            is_rd <= 1'b0;      is_ara <= 1'b0;     reg_rd_en <= 1'b0;
            reg_wr_en <= 1'b0;  reg_wr_data <= '0;  alert_ack <= 1'b0;
        end else begin
            scl_q     <= scl_f;
            sda_q     <= sda_f;
            reg_rd_en <= 1'b0;
            reg_wr_en <= 1'b0;
            alert_ack <= 1'b0;
            if (start_c) begin
                state  <= ST_RX;
                role   <= ROLE_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                state    <= ST_IDLE;
                reg_addr <= '0;
                sda_oe   <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bitcnt < BCW'(DW)) begin
                            shreg  <= {shreg[DW-2:0], sda_f};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == BCW'(DW)) begin
                            bitcnt <= '0;
                            case (role)
                                ROLE_ADDR: begin
                                    if (shreg[7:1] == own_addr) begin
                                        sda_oe <= 1'b1;  state <= ST_ACK;
                                        is_rd  <= shreg[0];  is_ara <= 1'b0;
                                    end else if (shreg[7:1] == ALERT_QUERY_ADDR && shreg[0] && irq_pending) begin
                                        sda_oe <= 1'b1;  state <= ST_ACK;
                                        is_rd  <= 1'b1;  is_ara <= 1'b1;
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end
                                ROLE_CMD: begin
                                    reg_addr <= shreg[REG_AW-1:0];
                                    sda_oe   <= 1'b1;
                                    state    <= ST_ACK;
                                end
                                default: begin
                                    reg_wr_en   <= 1'b1;
                                    reg_wr_data <= shreg;
                                    sda_oe      <= 1'b1;
                                    state       <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            case (role)
                                ROLE_ADDR: begin
                                    if (is_rd && is_ara) begin
                                        state  <= ST_TX;
                                        txsh   <= {own_addr, 1'b1};
                                        sda_oe <= ~own_addr[6];
                                    end else if (is_rd) begin
                                        state     <= ST_TX;
                                        reg_rd_en <= 1'b1;
                                        txsh      <= reg_rd_data;
                                        sda_oe    <= ~reg_rd_data[DW-1];
                                    end else begin
                                        role  <= ROLE_CMD;
                                        state <= ST_RX;
                                    end
                                end
                                ROLE_CMD: begin
                                    role  <= ROLE_DATA;
                                    state <= ST_RX;
                                end
                                default: state <= ST_IGNORE;
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                            if (is_ara && txsh[DW-1] && !sda_f) begin
                                state <= ST_IGNORE;
                            end
                        end else if (scl_fall) begin
                            if (bitcnt == BCW'(DW)) begin
                                sda_oe    <= 1'b0;
                                bitcnt    <= '0;
                                state     <= ST_IGNORE;
                                alert_ack <= is_ara;
                            end else begin
                                txsh   <= {txsh[DW-2:0], 1'b0};
                                sda_oe <= ~txsh[DW-2];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scl_f) |-> $stable(sda_oe));
    a_r4_wr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    a_r9_alert_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        alert_ack |=> !alert_ack);
    a_r6_stop_clears_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (reg_addr == '0));
    a_r2_released_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe);
endmodule

// File: rtl/smb_alert_target.sv
// Top level: filters both bus lines and drives the transfer engine.
// Assumes an external pull-up on SDA and a same-cycle register read path.
module smb_alert_target #(
    parameter int GLITCH_CYC = 4,
    parameter int REG_AW     = 5,
    parameter int DW         = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [3:0]        strap_addr,
    input  logic              irq_pending,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_rd_en,
    input  logic [DW-1:0]     reg_rd_data,
    output logic              reg_wr_en,
    output logic [DW-1:0]     reg_wr_data,
    output logic              alert_ack
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;

    assign raw_lines = {scl_i, sda_i};

    for (genvar gi = 0; gi < NLINES; gi++) begin : g_filt
        smbt_line_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[gi]),
            .line_f (filt_lines[gi])
        );
    end

    smbt_xfer_fsm #(.REG_AW(REG_AW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_f       (filt_lines[1]),
        .sda_f       (filt_lines[0]),
        .strap_addr  (strap_addr),
        .irq_pending (irq_pending),
        .reg_rd_data (reg_rd_data),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_rd_en   (reg_rd_en),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .alert_ack   (alert_ack)
    );
endmodule

// File: tb/smb_alert_target_tb_top.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, wired-AND SDA model, register file model.
module smb_alert_target_tb_top;
    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_line, sda_oe, irq_pending = 1'b0;
    logic [3:0] strap_addr = 4'b0101;
    logic [4:0] reg_addr;
    logic       reg_rd_en, reg_wr_en, alert_ack;
    logic [7:0] reg_rd_data, reg_wr_data;
    logic [7:0] mem [32];
    int         n_chk = 0, n_bad = 0, wr_cnt = 0, ack_cnt = 0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line    = sda_m & ~sda_oe;
    assign reg_rd_data = mem[reg_addr];

    smb_alert_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_addr(strap_addr), .irq_pending(irq_pending), .reg_addr(reg_addr),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .alert_ack(alert_ack)
    );

    // Register file model and strobe counters.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= 8'(i * 7 + 3);
        end else begin
            if (reg_wr_en) begin
                mem[reg_addr] <= reg_wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (alert_ack) ack_cnt <= ack_cnt + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic rbit(input logic drv, output logic s1, output logic s2);
        sda_m = drv; wq(); scl_m = 1'b1; wq(); s1 = sda_line; wq(); s2 = sda_line;
        scl_m = 1'b0; wq();
    endtask

    // Send a byte; gpos < 8 inserts a short SCL pulse before that bit.
    task automatic send_byte(input logic [7:0] b, input int gpos, output logic ack);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            if (7 - i == gpos) begin
                scl_m = 1'b1; repeat (2) @(negedge clk); scl_m = 1'b0; wq();
            end
            wbit(b[i]);
        end
        rbit(1'b1, s1, s2);
        ack = !s1 && !s2;
    endtask

    task automatic read_byte(input logic [7:0] drv, output logic [7:0] d, output logic stab);
        logic s1, s2;
        stab = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            rbit(drv[i], s1, s2);
            d = {d[6:0], s1};
            if (s1 != s2) stab = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk(!sda_oe && !alert_ack && !reg_wr_en && !reg_rd_en, "R1 reset outputs idle",
            {sda_oe, alert_ack, reg_wr_en}, 0);
    endtask

    task automatic t_write();
        logic a1, a2, a3; int w0;
        w0 = wr_cnt;
        bus_start(); send_byte(8'h4A, 8, a1); send_byte(8'hE7, 8, a2);
        send_byte(8'h5C, 8, a3); bus_stop();
        chk(a1 && a2 && a3, "R3 ack held low over ninth high", {a1, a2, a3}, 7);
        chk(mem[7] == 8'h5C, "R4 write lands at low five bits", mem[7], 8'h5C);
        chk(wr_cnt - w0 == 1, "R4 one write strobe", wr_cnt - w0, 1);
    endtask

    task automatic t_read();
        logic a1, a2, a3, st; logic [7:0] d;
        bus_start(); send_byte(8'h4A, 8, a1); send_byte(8'h07, 8, a2);
        bus_start(); send_byte(8'h4B, 8, a3); read_byte(8'hFF, d, st);
        wbit(1'b1); bus_stop();
        chk(a1 && a2 && a3, "R5 acks in read", {a1, a2, a3}, 7);
        chk(d == 8'h5C, "R5 read returns pointed reg", d, 8'h5C);
        chk(st, "R10 data stable while SCL high", st, 1);
    endtask

    task automatic t_recv();
        logic a1, st; logic [7:0] d;
        bus_start(); send_byte(8'h4B, 8, a1); read_byte(8'hFF, d, st); wbit(1'b1); bus_stop();
        chk(a1 && d == mem[0], "R6 bare read gives register 0", d, mem[0]);
    endtask

    task automatic t_bad_addr();
        logic a1, st; logic [7:0] d;
        bus_start(); send_byte(8'h66, 8, a1); read_byte(8'hFF, d, st); bus_stop();
        chk(!a1, "R2 foreign address not acked", a1, 0);
        chk(d == 8'hFF, "R2 SDA stays released", d, 8'hFF);
    endtask

    task automatic t_ara_idle();
        logic a1;
        irq_pending = 1'b0;
        bus_start(); send_byte(8'h19, 8, a1); bus_stop();
        chk(!a1, "R7 alert query not acked without irq", a1, 0);
    endtask

    task automatic t_ara_win();
        logic a1, st; logic [7:0] d; int c0;
        irq_pending = 1'b1; c0 = ack_cnt;
        bus_start(); send_byte(8'h19, 8, a1); read_byte(8'hFF, d, st); wbit(1'b1); bus_stop();
        chk(a1 && d == 8'h4B, "R7 alert reply is own address and 1", d, 8'h4B);
        chk(ack_cnt - c0 == 1, "R9 one alert_ack pulse", ack_cnt - c0, 1);
    endtask

    task automatic t_ara_lose();
        logic a1, st; logic [7:0] d; int c0;
        irq_pending = 1'b1; c0 = ack_cnt;
        bus_start(); send_byte(8'h19, 8, a1); read_byte(8'h45, d, st); wbit(1'b1); bus_stop();
        chk(d == 8'h45, "R8 released after lost arbitration", d, 8'h45);
        chk(ack_cnt == c0, "R8 no alert_ack when lost", ack_cnt - c0, 0);
        irq_pending = 1'b0;
    endtask

    task automatic t_abort();
        logic a1, a2, a3;
        bus_start(); wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b1);
        bus_start(); send_byte(8'h4A, 8, a1); send_byte(8'h03, 8, a2);
        send_byte(8'h77, 8, a3); bus_stop();
        chk(a1 && a2 && a3 && mem[3] == 8'h77, "R11 restart mid-byte aborts", mem[3], 8'h77);
    endtask

    task automatic t_glitch();
        logic a0, a1, a2, a3;
        scl_m = 1'b1; sda_m = 1'b1; wq();
        sda_m = 1'b0; repeat (2) @(negedge clk); sda_m = 1'b1; wq();
        scl_m = 1'b0; wq();
        send_byte(8'h4A, 8, a0); bus_stop();
        chk(!a0, "R1 no ack without START after SDA glitch", a0, 0);
        bus_start(); send_byte(8'h4A, 8, a1); send_byte(8'h0B, 3, a2);
        send_byte(8'h99, 8, a3); bus_stop();
        chk(a1 && a2 && a3 && mem[11] == 8'h99, "R12 SCL glitch ignored", mem[11], 8'h99);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_recv();
        t_bad_addr();
        t_ara_idle();
        t_ara_win();
        t_ara_lose();
        t_abort();
        t_glitch();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule